// File: doc/BRIEF.md
# Shared Signed/Unsigned Magnitude Comparator

This block compares two N-bit operands and reports whether the first is greater than, equal to or less than the second. A single mode input picks how the operands are read: as plain unsigned binary, or as two's-complement signed values. The result flags are purely combinational and settle within the same cycle as the inputs.

The comparison of the N-1 bits below the top bit is built once and used by both modes. In signed mode two operands with the same sign bit order exactly as their remaining bits do, read as unsigned values. So the mode only changes how the two top bits resolve a mismatch. When the top bits are equal, the shared low-bit result decides. When they differ, the operand whose top bit is 1 wins in unsigned mode, and the operand whose top bit is 0 wins in signed mode. The equal and less-than outputs can be removed by parameter. When removed, their ports are tied to 0.

Top module: `mag_cmp_shared`

## Requirements
- R1: With `signed_mode` = 0, `a_gt` is 1 exactly when `opa` > `opb` as N-bit unsigned numbers.
- R2: With `signed_mode` = 1 and differing top bits, `a_gt` is 1 exactly when `opa[N-1]` is 0, meaning `opa` is the non-negative operand.
- R3: With `signed_mode` = 1 and equal top bits, `a_gt` is 1 exactly when `opa[N-2:0]` > `opb[N-2:0]` unsigned. This also holds for negative pairs: at N=4, 4'b1111 > 4'b1100 > 4'b1001.
- R4: `a_eq` is 1 exactly when all N bits of the operands match, whatever the value of `signed_mode`.
- R5: `a_lt` is 1 exactly when `opa` < `opb` under the selected mode, and exactly one of `a_gt`, `a_eq`, `a_lt` is 1.
- R6: With `signed_mode` = 0 and differing top bits, `a_gt` equals `opa[N-1]`, which is the reverse of the signed rule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | First operand |
| opb | input | N | Second operand |
| signed_mode | input | 1 | 0 = unsigned, 1 = two's-complement signed |
| a_gt | output | 1 | `opa` greater than `opb` |
| a_eq | output | 1 | Operands bit-identical (0 when disabled) |
| a_lt | output | 1 | `opa` less than `opb` (0 when disabled) |

## Verification
Every operand pair at N=4 is applied in both modes. Each is checked against a reference unsigned or signed comparison, which separates the two top-bit rules from each other and from the shared low-bit path. A directed pass with pairs that share the sign bit and are negative checks that the low-bit ordering alone decides the result. A pass that applies each pair in both modes checks that equality ignores the mode. The zero-input state confirms the idle flags.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  typedef enum logic {
    CMP_UNSIGNED = 1'b0,
    CMP_SIGNED   = 1'b1
  } cmp_mode_e;

  typedef struct packed {
    logic gt;
    logic eq;
  } low_res_t;
endpackage

// File: rtl/low_bits_cmp.sv
module low_bits_cmp #(
  parameter int M = 3
) (
  input  logic [M-1:0]          x,
  input  logic [M-1:0]          y,
  output mag_cmp_pkg::low_res_t res
);
  logic found;
  logic gt_bit;

  always_comb begin
    found  = 1'b0;
    gt_bit = 1'b0;
    for (int i = M - 1; i >= 0; i--) begin
      if (!found && (x[i] != y[i])) begin
        found  = 1'b1;
        gt_bit = x[i];
      end
    end
  end

  assign res.gt = gt_bit;
  assign res.eq = ~found;
endmodule

// File: rtl/msb_steer.sv
module msb_steer (
  input  logic                    msb_a,
  input  logic                    msb_b,
  input  mag_cmp_pkg::cmp_mode_e  mode,
  input  mag_cmp_pkg::low_res_t   low,
  output logic                    gt,
  output logic                    eq
);
  import mag_cmp_pkg::*;

  logic msb_diff;

  assign msb_diff = msb_a ^ msb_b;

  always_comb begin
    if (msb_diff) begin
      gt = (mode == CMP_SIGNED) ? ~msb_a : msb_a;
    end else begin
      gt = low.gt;
    end
    eq = ~msb_diff & low.eq;
  end

  always_comb begin
    if (msb_diff && mode == CMP_SIGNED) begin
      // R2
      sign_split_chk: assert (gt == (msb_b & ~msb_a));
    end
    if (msb_diff && mode == CMP_UNSIGNED) begin
      // R6
      usign_split_chk: assert (gt == (msb_a & ~msb_b));
    end
  end
endmodule

// File: rtl/mag_cmp_shared.sv
module mag_cmp_shared #(
  parameter int N      = 4,
  parameter bit HAS_EQ = 1'b1,
  parameter bit HAS_LT = 1'b1
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic         signed_mode,
  output logic         a_gt,
  output logic         a_eq,
  output logic         a_lt
);
  import mag_cmp_pkg::*;

  localparam int LOW_W = N - 1;

  low_res_t  low_r;
  cmp_mode_e mode;
  logic      gt_i;
  logic      eq_i;

  assign mode = cmp_mode_e'(signed_mode);

  low_bits_cmp #(.M(LOW_W)) u_low (
    .x   (opa[LOW_W-1:0]),
    .y   (opb[LOW_W-1:0]),
    .res (low_r)
  );

  msb_steer u_steer (
    .msb_a (opa[N-1]),
    .msb_b (opb[N-1]),
    .mode  (mode),
    .low   (low_r),
    .gt    (gt_i),
    .eq    (eq_i)
  );

  assign a_gt = gt_i;

  generate
    if (HAS_EQ) begin : g_eq
      assign a_eq = eq_i;
    end else begin : g_no_eq
      assign a_eq = 1'b0;
    end
    if (HAS_LT) begin : g_lt
      assign a_lt = ~gt_i & ~eq_i;
    end else begin : g_no_lt
      assign a_lt = 1'b0;
    end
  endgenerate

  always_comb begin
    if (opa[N-1] == opb[N-1]) begin
      // R3
      same_sign_chk: assert (a_gt == (opa[LOW_W-1:0] > opb[LOW_W-1:0]));
    end
    if (HAS_EQ) begin
      // R4
      eq_match_chk: assert (a_eq == (opa == opb));
    end
    if (HAS_EQ && HAS_LT) begin
      // R5
      one_flag_chk: assert ($onehot({a_gt, a_eq, a_lt}));
    end
  end
endmodule

// File: tb/sim_mag_cmp_shared.sv
module sim_mag_cmp_shared;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int WATCHDOG_CYC = 20000;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic         signed_mode;
  logic         a_gt;
  logic         a_eq;
  logic         a_lt;

  int  checks;
  int  failures;
  bit  done;

  mag_cmp_shared #(.N(W)) u0 (
    .opa         (opa),
    .opb         (opb),
    .signed_mode (signed_mode),
    .a_gt        (a_gt),
    .a_eq        (a_eq),
    .a_lt        (a_lt)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s opa=%b opb=%b mode=%0b actual=%0b expected=%0b",
               req, opa, opb, signed_mode, act, exp);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic m);
    @(negedge clk);
    opa = a;
    opb = b;
    signed_mode = m;
    #(CLK_PERIOD / 4);
  endtask

  task automatic t_idle;
    apply('0, '0, 1'b0);
    chk("R4 idle eq", a_eq, 1'b1);
    chk("R1 idle gt", a_gt, 1'b0);
    chk("R5 idle lt", a_lt, 1'b0);
  endtask

  task automatic t_unsigned_all;
    for (int i = 0; i < (1 << W); i++) begin
      for (int j = 0; j < (1 << W); j++) begin
        apply(W'(i), W'(j), 1'b0);
        chk("R1 unsigned gt", a_gt, i > j);
        chk("R4 unsigned eq", a_eq, i == j);
        chk("R5 unsigned lt", a_lt, i < j);
        if (opa[W-1] != opb[W-1]) chk("R6 msb rule", a_gt, opa[W-1]);
      end
    end
  endtask

  task automatic t_signed_all;
    for (int i = 0; i < (1 << W); i++) begin
      for (int j = 0; j < (1 << W); j++) begin
        logic signed [W-1:0] sa;
        logic signed [W-1:0] sb;
        sa = W'(i);
        sb = W'(j);
        apply(W'(i), W'(j), 1'b1);
        if (opa[W-1] != opb[W-1]) chk("R2 sign differ", a_gt, sa > sb);
        else chk("R3 same sign", a_gt, sa > sb);
        chk("R4 signed eq", a_eq, i == j);
        chk("R5 signed lt", a_lt, sa < sb);
      end
    end
  endtask

  task automatic t_negatives;
    apply(4'b1111, 4'b1100, 1'b1);
    chk("R3 -1 > -4", a_gt, 1'b1);
    apply(4'b1100, 4'b1001, 1'b1);
    chk("R3 -4 > -7", a_gt, 1'b1);
    apply(4'b1001, 4'b1111, 1'b1);
    chk("R3 -7 < -1", a_lt, 1'b1);
    apply(4'b0111, 4'b1000, 1'b1);
    chk("R2 7 > -8", a_gt, 1'b1);
    apply(4'b0111, 4'b1000, 1'b0);
    chk("R6 7 < 8 unsigned", a_lt, 1'b1);
  endtask

  task automatic t_eq_mode_free;
    for (int i = 0; i < (1 << W); i++) begin
      apply(W'(i), W'(i), 1'b0);
      chk("R4 eq mode0", a_eq, 1'b1);
      apply(W'(i), W'(i), 1'b1);
      chk("R4 eq mode1", a_eq, 1'b1);
      apply(W'(i), W'(i ^ 8), 1'b1);
      chk("R4 neq msb", a_eq, 1'b0);
    end
  endtask

  initial begin
    checks = 0;
    failures = 0;
    done = 1'b0;
    rst_n = 1'b0;
    opa = '0;
    opb = '0;
    signed_mode = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_unsigned_all();
    t_signed_all();
    t_negatives();
    t_eq_mode_free();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule